// File: doc/BRIEF.md
# Consecutive-Zero Auto-Mute Controller

This block decides, for one digital-to-analog output channel, whether that output should be silenced. It watches a two's complement sample stream that arrives with a frame strobe and counts how many zero samples arrive in a row. After a fixed number of zero samples in a row, it raises an automatic mute flag. One non-zero sample drops that flag again. This means muting is slow and unmuting is immediate.

A mute bit controlled by software works alongside the automatic flag. The automatic feature has its own enable bit. The mute the analog stage acts on is the OR of the software mute and the automatic flag. That combined value is captured on frame strobes only, so it changes at frame boundaries. A chip has one instance per output.

Top module: `zero_automute`

## Requirements
- R1: While `rst_ni` is low and after reset is released, `mute_o` and `auto_mute_o` are 0, and the zero-run count is 0.
- R2: With `auto_en_i` high, `auto_mute_o` rises at the clock edge of the ZERO_LIMIT-th frame strobe that carries an all-zero `sample_i` in a row, and not before.
- R3: With `auto_en_i` high, a frame strobe whose `sample_i` has any bit set clears `auto_mute_o` at that same edge and resets the run, so a further ZERO_LIMIT zero frames are needed to mute again.
- R4: A sample presented on a clock with `frame_i` low is ignored. It neither advances nor resets the run.
- R5: The run count saturates at ZERO_LIMIT and never wraps. Zero runs of any length keep `auto_mute_o` high.
- R6: When `auto_en_i` is low, `auto_mute_o` is 0 from the next clock edge on, and the run count is held at 0. Zero frames seen while it is low do not count toward a later mute.
- R7: `mute_o` changes only at clock edges where `frame_i` is high. At such an edge it takes `man_mute_i` OR the automatic flag as updated at that same edge.
- R8: Negative samples are non-zero. A sample with only the sign bit set (most negative value) and the all-ones value (-1) each break a zero run.
- R9: `man_mute_i` mutes the output on the next frame strobe, whatever the state of `auto_en_i` and the sample values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| frame_i | input | 1 | Frame strobe; one clock wide per sample |
| sample_i | input | DATA_W | Two's complement sample, valid with `frame_i` |
| man_mute_i | input | 1 | Software mute bit |
| auto_en_i | input | 1 | Enable for the consecutive-zero automatic mute |
| mute_o | output | 1 | Effective mute: software OR automatic, updated on frame strobes |
| auto_mute_o | output | 1 | Automatic mute flag |

## Verification
The bench builds the block with DATA_W = 8 and ZERO_LIMIT = 8. The short limit makes full zero runs, runs one frame short of the limit, and long saturated runs cheap to drive many times within one run. The narrow word makes the sign-bit-only and all-ones samples easy to hit exactly. Frame strobes are spaced irregularly, with idle clocks in between that carry non-zero data. This shows that only strobed samples count, and that the output moves only on strobe edges.

// File: rtl/zmute_pkg.sv
package zmute_pkg;
  localparam int unsigned DEF_DATA_W     = 16;
  localparam int unsigned DEF_ZERO_LIMIT = 512;

  // automatic flag: registered value and its next-state value
  typedef struct packed {
    logic flag_q;
    logic flag_d;
  } auto_flag_t;
endpackage

// File: rtl/zmute_run_counter.sv
module zmute_run_counter
  import zmute_pkg::*;
#(
  parameter int unsigned DATA_W     = DEF_DATA_W,
  parameter int unsigned ZERO_LIMIT = DEF_ZERO_LIMIT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              auto_en_i,
  output auto_flag_t        flag_o
);
  localparam int unsigned CNT_W = $clog2(ZERO_LIMIT + 1);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(ZERO_LIMIT);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             flag_q, flag_d;
  logic             is_zero;

  assign is_zero = ~|sample_i;

  always_comb begin
    cnt_d  = cnt_q;
    flag_d = flag_q;
    if (!auto_en_i) begin
      cnt_d  = '0;
      flag_d = 1'b0;
    end else if (frame_i) begin
      if (is_zero) begin
        if (cnt_q != LIM) cnt_d = cnt_q + 1'b1;
        if (cnt_d == LIM) flag_d = 1'b1;
      end else begin
        cnt_d  = '0;
        flag_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign flag_o.flag_q = flag_q;
  assign flag_o.flag_d = flag_d;

  p_set_at_limit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_en_i && frame_i && is_zero && cnt_q == LIM - 1'b1) |=> flag_q);
  p_nonzero_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_en_i && frame_i && !is_zero) |=> (!flag_q && cnt_q == '0));
  p_idle_holds_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_en_i && !frame_i) |=> ($stable(cnt_q) && $stable(flag_q)));
  p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIM);
  p_disable_drops_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_en_i |=> (!flag_q && cnt_q == '0));
endmodule

// File: rtl/zmute_out_reg.sv
module zmute_out_reg
  import zmute_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       frame_i,
  input  logic       man_mute_i,
  input  auto_flag_t flag_i,
  output logic       mute_o
);
  logic mute_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mute_q <= 1'b0;
    else if (frame_i) mute_q <= man_mute_i | flag_i.flag_d;
  end

  assign mute_o = mute_q;

  p_strobe_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> $stable(mute_q));
  p_manual_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && man_mute_i) |=> mute_q);
endmodule

// File: rtl/zero_automute.sv
module zero_automute
  import zmute_pkg::*;
#(
  parameter int unsigned DATA_W     = DEF_DATA_W,
  parameter int unsigned ZERO_LIMIT = DEF_ZERO_LIMIT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              man_mute_i,
  input  logic              auto_en_i,
  output logic              mute_o,
  output logic              auto_mute_o
);
  auto_flag_t flag;

  zmute_run_counter #(
    .DATA_W    (DATA_W),
    .ZERO_LIMIT(ZERO_LIMIT)
  ) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .frame_i  (frame_i),
    .sample_i (sample_i),
    .auto_en_i(auto_en_i),
    .flag_o   (flag)
  );

  zmute_out_reg u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .frame_i   (frame_i),
    .man_mute_i(man_mute_i),
    .flag_i    (flag),
    .mute_o    (mute_o)
  );

  assign auto_mute_o = flag.flag_q;

  p_reset_quiet_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (!mute_o && !auto_mute_o));
endmodule

// File: tb/sim_zero_automute.sv
`timescale 1ns/1ps
module sim_zero_automute;
  localparam int DW = 8;
  localparam int LIM = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frame = 1'b0;
  logic [DW-1:0] sample = '0;
  logic          man = 1'b0;
  logic          en = 1'b0;
  logic          mute, amute;

  int total = 0;
  int bad = 0;
  string tag = "R1";

  // behavioural reference state
  int m_run = 0;
  bit m_auto = 0;
  bit m_mute = 0;

  always #2.5 clk = ~clk;

  zero_automute #(.DATA_W(DW), .ZERO_LIMIT(LIM)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .frame_i(frame), .sample_i(sample),
    .man_mute_i(man), .auto_en_i(en), .mute_o(mute), .auto_mute_o(amute)
  );

  task automatic check(input string t, input bit act_m, input bit act_a,
                       input bit exp_m, input bit exp_a);
    total++;
    if (act_m !== exp_m || act_a !== exp_a) begin
      bad++;
      $display("FAIL %s t=%0t mute=%b/%b auto=%b/%b (actual/expected)",
               t, $time, act_m, exp_m, act_a, exp_a);
    end
  endtask

  // one clock: apply inputs, advance the model, compare after the edge
  task automatic step(input bit f, input logic [DW-1:0] s, input bit mm, input bit e);
    @(negedge clk);
    frame = f; sample = s; man = mm; en = e;
    @(posedge clk);
    if (!e) begin
      m_run = 0; m_auto = 0;
    end else if (f) begin
      if (s == 0) begin
        if (m_run < LIM) m_run++;
        if (m_run == LIM) m_auto = 1;
      end else begin
        m_run = 0; m_auto = 0;
      end
    end
    if (f) m_mute = mm | m_auto;
    #1;
    check(tag, mute, amute, m_mute, m_auto);
  endtask

  task automatic zeros(input int n, input bit mm);
    for (int i = 0; i < n; i++) begin
      step(1'b1, '0, mm, 1'b1);
      step(1'b0, 8'h5A, mm, 1'b1); // idle clock with junk data
    end
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tag = "R1";
    #12;
    check("R1 in reset", mute, amute, 1'b0, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    step(1'b0, '0, 1'b0, 1'b0);

    // R2: one short of the limit stays unmuted, the limit mutes
    tag = "R2";
    zeros(LIM - 1, 1'b0);
    check("R2 short run", mute, amute, 1'b0, 1'b0);
    zeros(1, 1'b0);
    check("R2 at limit", mute, amute, 1'b1, 1'b1);

    // R5: long run saturates, no wrap
    tag = "R5";
    zeros(3 * LIM, 1'b0);
    check("R5 saturated", mute, amute, 1'b1, 1'b1);

    // R3: one non-zero unmutes at once, full run needed again
    tag = "R3";
    step(1'b1, 8'h01, 1'b0, 1'b1);
    check("R3 instant clear", mute, amute, 1'b0, 1'b0);
    zeros(LIM - 1, 1'b0);
    check("R3 rerun short", mute, amute, 1'b0, 1'b0);
    zeros(1, 1'b0);

    // R8: sign bit only and all-ones break the run
    tag = "R8";
    step(1'b1, 8'h80, 1'b0, 1'b1);
    check("R8 sign bit", mute, amute, 1'b0, 1'b0);
    zeros(LIM - 1, 1'b0);
    step(1'b1, 8'hFF, 1'b0, 1'b1);
    check("R8 minus one", mute, amute, 1'b0, 1'b0);
    zeros(LIM, 1'b0);

    // R4: idle clocks with non-zero data are ignored
    tag = "R4";
    step(1'b1, 8'h11, 1'b0, 1'b1);
    for (int i = 0; i < LIM; i++) begin
      step(1'b1, '0, 1'b0, 1'b1);
      step(1'b0, 8'h7F, 1'b0, 1'b1);
      step(1'b0, 8'h80, 1'b0, 1'b1);
    end
    check("R4 run survives idle data", mute, amute, 1'b1, 1'b1);

    // R6/R7: disable drops flag now, mute waits for a strobe
    tag = "R6";
    step(1'b0, '0, 1'b0, 1'b0);
    check("R6 flag dropped, R7 mute held", mute, amute, 1'b1, 1'b0);
    tag = "R7";
    step(1'b1, '0, 1'b0, 1'b0);
    check("R7 mute follows strobe", mute, amute, 1'b0, 1'b0);
    tag = "R6";
    for (int i = 0; i < 2 * LIM; i++) step(1'b1, '0, 1'b0, 1'b0);
    check("R6 zeros ignored when off", mute, amute, 1'b0, 1'b0);
    zeros(LIM - 1, 1'b0);
    check("R6 run restarts from zero", mute, amute, 1'b0, 1'b0);
    zeros(1, 1'b0);

    // R9: manual mute regardless of enable and data
    tag = "R9";
    step(1'b1, 8'h33, 1'b0, 1'b0);
    step(1'b0, 8'h33, 1'b1, 1'b0);
    check("R9 waits for strobe", mute, amute, 1'b0, 1'b0);
    step(1'b1, 8'h33, 1'b1, 1'b0);
    check("R9 manual mute", mute, amute, 1'b1, 1'b0);
    step(1'b1, 8'h33, 1'b1, 1'b1);
    step(1'b1, 8'h00, 1'b0, 1'b1);
    check("R9 manual released", mute, amute, 1'b0, 1'b0);

    // R1: async reset mid-mute
    tag = "R1";
    zeros(LIM, 1'b0);
    @(negedge clk); rst_n = 1'b0;
    #1;
    check("R1 async reset", mute, amute, 1'b0, 1'b0);
    m_run = 0; m_auto = 0; m_mute = 0;
    @(negedge clk); rst_n = 1'b1;
    zeros(LIM - 1, 1'b0);
    check("R1 count cleared by reset", mute, amute, 1'b0, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule